// File: doc/BRIEF.md
# Flash Write-Status Poller

This controller sits on the host side of a parallel NOR-style flash. After the host has issued a program, sector-erase or chip-erase command sequence, it pulses `start` with the operation type, the target address, the written data and the chosen polling method. The controller then reads the device's status word through a single-beat read port. It keeps reading until the status bits show that the embedded operation has finished, has hit the device's internal pulse limit, or has been suspended. It then reports one result code. Issuing commands and bus electrical timing are left to other logic.

Two polling methods are available. Toggle polling reads the status in pairs and compares bit 6 between the two reads. Data polling compares bit 7 against the value expected at completion. In both methods a set bit 5 is never trusted alone: the status is read again to rule out a finish that coincided with the limit flag. When the operation ends, except when it is suspended, the controller raises a one-cycle request for the reset command, so the device returns to array reads before the result is reported. A read counter ends the polling with a timeout code if no decision is reached.

States: `ST_IDLE` (waiting for `start`), `ST_TG_A` / `ST_TG_B` (first and second read of a toggle pair), `ST_RC_A` / `ST_RC_B` (recheck pair after bit 5 rose), `ST_DP_RD` (data-poll read), `ST_DP_RC` (data-poll recheck), `ST_CLEAN` (reset command request), `ST_REPORT` (result pulse). Transitions: IDLE→TG_A or DP_RD on start; TG_A→TG_B on ack; TG_B→REPORT (suspended), →CLEAN (done or timeout), →RC_A (bit 5 set while toggling), →TG_A (still toggling); RC_A→RC_B; RC_B→CLEAN; DP_RD→CLEAN (match or timeout), →DP_RC (bit 5 set), →DP_RD (no match); DP_RC→CLEAN; CLEAN→REPORT; REPORT→IDLE.

Top module: `fsp_poll_ctrl`

## Requirements
- R1: After reset, `busy`, `rd_req`, `rst_cmd_req` and `res_valid` are all low.
- R2: The polling address is `tgt_addr` for a program (`op`=0, and also for the unused code 3). It is `tgt_addr` with its low `OFS_W` bits cleared for a sector erase (`op`=1) or a chip erase (`op`=2). The address is held for the whole operation.
- R3: `rd_req` stays high with a stable `rd_addr` until a cycle with `rd_ack` high; `rd_data` is taken in that cycle.
- R4: In toggle mode (`use_dq7`=0) the status is read in pairs. If bit 6 is equal in both reads of a pair, the operation completes with code 0 (done).
- R5: In toggle mode, if bit 6 differs within a pair and bit 5 of the second read is 0, a new pair is read.
- R6: In toggle mode, if bit 6 differs and bit 5 of the second read is 1, one more pair is read. If bit 6 is equal in that pair, the code is 0; otherwise it is 1 (failed).
- R7: For an erase in toggle mode, a pair with bit 6 equal and bit 2 different gives code 2 (suspended), and no reset command request is raised.
- R8: In data mode (`use_dq7`=1) a read whose bit 7 equals the expected bit gives code 0. The expected bit is `exp_data[7]` for a program and 1 for an erase. On a mismatch with bit 5 = 1, one more read is made: a match gives code 0, a mismatch gives code 1. On a mismatch with bit 5 = 0, polling continues.
- R9: If `MAX_READS` reads have completed without a decision at the end of a poll round, the result is code 3 (timeout).
- R10: For codes 0, 1 and 3, `rst_cmd_req` is high for exactly one cycle, and `res_valid` follows in the next cycle.
- R11: `res_valid` is a one-cycle pulse carrying `res_code`. `busy` is high from the cycle after an accepted `start` through the result cycle, and `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (one-cycle pulse) |
| op | input | 2 | 0 program, 1 sector erase, 2 chip erase |
| use_dq7 | input | 1 | 1 selects data polling, 0 selects toggle polling |
| tgt_addr | input | AW | Address of the program or of the erased sector |
| exp_data | input | DW | Data written by the program operation |
| rd_req | output | 1 | Status read request |
| rd_addr | output | AW | Status read address |
| rd_ack | input | 1 | Read completion, data valid this cycle |
| rd_data | input | DW | Status word returned by the flash |
| rst_cmd_req | output | 1 | Request to issue the reset command |
| busy | output | 1 | Polling in progress |
| res_valid | output | 1 | Result pulse |
| res_code | output | 2 | 0 done, 1 failed, 2 suspended, 3 timeout |

## Verification
The bench builds the controller with a 12-bit address, a 4-bit sector offset and a read limit of 8. With these values a sector-aligned erase address differs visibly from a program address, and both toggle and data timeouts can be reached within a handful of scripted status words. A scripted flash answers every read from a per-scenario list of status words. This makes it possible to reach the bit-5 recheck that recovers, the recheck that fails, suspension, and a start pulse that arrives mid-operation.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_RSVD = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RC_OK   = 2'd0,
        RC_ERR  = 2'd1,
        RC_SUSP = 2'd2,
        RC_TMO  = 2'd3
    } res_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TG_A,
        ST_TG_B,
        ST_RC_A,
        ST_RC_B,
        ST_DP_RD,
        ST_DP_RC,
        ST_CLEAN,
        ST_REPORT
    } st_e;

    localparam int BIT_POLL7 = 7;
    localparam int BIT_TOG6  = 6;
    localparam int BIT_LIM5  = 5;
    localparam int BIT_TOG2  = 2;
endpackage

// File: rtl/fsp_addr_sel.sv
module fsp_addr_sel
    import fsp_pkg::*;
#(
    parameter int AW    = 20,
    parameter int OFS_W = 15
) (
    input  logic [1:0]    op,
    input  logic [AW-1:0] tgt_addr,
    output logic [AW-1:0] poll_addr,
    output logic          is_erase
);
    localparam int SEC_W = AW - OFS_W;

    always_comb begin
        unique case (op_e'(op))
            OP_SECT, OP_CHIP: is_erase = 1'b1;
            default:          is_erase = 1'b0;
        endcase
    end

    always_comb begin
        if (is_erase) poll_addr = {tgt_addr[AW-1 -: SEC_W], {OFS_W{1'b0}}};
        else          poll_addr = tgt_addr;
    end
endmodule

// File: rtl/fsp_status_eval.sv
module fsp_status_eval
    import fsp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [1:0]    prev_bits,
    input  logic [DW-1:0] cur,
    input  logic          exp7,
    output logic          dq6_moved,
    output logic          dq2_moved,
    output logic          limit_hit,
    output logic          dq7_match
);
    logic unused_bits;
    assign unused_bits = ^{cur[DW-1:8], cur[4:3], cur[1:0]};

    assign dq6_moved = prev_bits[1] ^ cur[BIT_TOG6];
    assign dq2_moved = prev_bits[0] ^ cur[BIT_TOG2];
    assign limit_hit = cur[BIT_LIM5];
    assign dq7_match = (cur[BIT_POLL7] == exp7);
endmodule

// File: rtl/fsp_read_wdog.sv
module fsp_read_wdog #(
    parameter int MAX_READS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expire_now
);
    localparam int CW = $clog2(MAX_READS + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear)                  cnt_q <= '0;
        else if (tick && cnt_q != CW'(MAX_READS)) cnt_q <= cnt_q + 1'b1;
    end

    // this read is the MAX_READS-th (or later) of the operation
    assign expire_now = tick && (cnt_q >= CW'(MAX_READS - 1));

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_READS));
endmodule

// File: rtl/fsp_poll_ctrl.sv
module fsp_poll_ctrl
    import fsp_pkg::*;
#(
    parameter int AW        = 20,
    parameter int DW        = 16,
    parameter int OFS_W     = 15,
    parameter int MAX_READS = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic          use_dq7,
    input  logic [AW-1:0] tgt_addr,
    input  logic [DW-1:0] exp_data,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          rst_cmd_req,
    output logic          busy,
    output logic          res_valid,
    output logic [1:0]    res_code
);
    st_e           st_q, st_d;
    res_e          code_q, code_d;
    logic [AW-1:0] addr_q;
    logic          erase_q;
    logic          exp7_q;
    logic [1:0]    prev_q;

    logic [AW-1:0] sel_addr;
    logic          sel_erase;
    logic          ev_t6, ev_t2, ev_lim, ev_d7;
    logic          wd_expire;
    logic          accept;
    logic          unused_exp;

    assign unused_exp = ^{exp_data[DW-1:8], exp_data[6:0]};
    assign accept     = (st_q == ST_IDLE) && start;

    fsp_addr_sel #(.AW(AW), .OFS_W(OFS_W)) u_addr (
        .op        (op),
        .tgt_addr  (tgt_addr),
        .poll_addr (sel_addr),
        .is_erase  (sel_erase)
    );

    fsp_status_eval #(.DW(DW)) u_eval (
        .prev_bits (prev_q),
        .cur       (rd_data),
        .exp7      (exp7_q),
        .dq6_moved (ev_t6),
        .dq2_moved (ev_t2),
        .limit_hit (ev_lim),
        .dq7_match (ev_d7)
    );

    fsp_read_wdog #(.MAX_READS(MAX_READS)) u_wdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .tick       (rd_ack && rd_req),
        .expire_now (wd_expire)
    );

    // operation context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            erase_q <= 1'b0;
            exp7_q  <= 1'b0;
            prev_q  <= '0;
        end else begin
            if (accept) begin
                addr_q  <= sel_addr;
                erase_q <= sel_erase;
                exp7_q  <= sel_erase ? 1'b1 : exp_data[BIT_POLL7];
            end
            if (rd_ack && (st_q == ST_TG_A || st_q == ST_RC_A))
                prev_q <= {rd_data[BIT_TOG6], rd_data[BIT_TOG2]};
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            code_q <= RC_OK;
        end else begin
            st_q   <= st_d;
            code_q <= code_d;
        end
    end

    // next state
    always_comb begin
        st_d   = st_q;
        code_d = code_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start) st_d = use_dq7 ? ST_DP_RD : ST_TG_A;
            end
            ST_TG_A: begin
                if (rd_ack) st_d = ST_TG_B;
            end
            ST_TG_B: begin
                if (rd_ack) begin
                    if (!ev_t6) begin
                        if (erase_q && ev_t2) begin
                            st_d   = ST_REPORT;
                            code_d = RC_SUSP;
                        end else begin
                            st_d   = ST_CLEAN;
                            code_d = RC_OK;
                        end
                    end else if (ev_lim) begin
                        st_d = ST_RC_A;
                    end else if (wd_expire) begin
                        st_d   = ST_CLEAN;
                        code_d = RC_TMO;
                    end else begin
                        st_d = ST_TG_A;
                    end
                end
            end
            ST_RC_A: begin
                if (rd_ack) st_d = ST_RC_B;
            end
            ST_RC_B: begin
                if (rd_ack) begin
                    st_d   = ST_CLEAN;
                    code_d = ev_t6 ? RC_ERR : RC_OK;
                end
            end
            ST_DP_RD: begin
                if (rd_ack) begin
                    if (ev_d7) begin
                        st_d   = ST_CLEAN;
                        code_d = RC_OK;
                    end else if (ev_lim) begin
                        st_d = ST_DP_RC;
                    end else if (wd_expire) begin
                        st_d   = ST_CLEAN;
                        code_d = RC_TMO;
                    end
                end
            end
            ST_DP_RC: begin
                if (rd_ack) begin
                    st_d   = ST_CLEAN;
                    code_d = ev_d7 ? RC_OK : RC_ERR;
                end
            end
            ST_CLEAN:  st_d = ST_REPORT;
            ST_REPORT: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ST_TG_A, ST_TG_B, ST_RC_A, ST_RC_B, ST_DP_RD, ST_DP_RC: rd_req = 1'b1;
            default: rd_req = 1'b0;
        endcase
        rd_addr     = addr_q;
        rst_cmd_req = (st_q == ST_CLEAN);
        res_valid   = (st_q == ST_REPORT);
        res_code    = code_q;
        busy        = (st_q != ST_IDLE);
    end

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    assert_erase_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && erase_q) |-> (rd_addr[OFS_W-1:0] == '0));

    assert_clean_then_report_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd_req |=> (res_valid && res_code != RC_SUSP));

    assert_result_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_susp_no_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code == RC_SUSP) |-> !$past(rst_cmd_req));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_req && !rst_cmd_req && !res_valid));
endmodule

// File: tb/sim_fsp_poll_ctrl.sv
module sim_fsp_poll_ctrl;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int OFS_W = 4;
    localparam int MAX_READS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    op = 2'd0;
    logic          use_dq7 = 1'b0;
    logic [AW-1:0] tgt_addr = '0;
    logic [DW-1:0] exp_data = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic          rst_cmd_req;
    logic          busy;
    logic          res_valid;
    logic [1:0]    res_code;

    always #5 clk = ~clk;

    fsp_poll_ctrl #(.AW(AW), .DW(DW), .OFS_W(OFS_W), .MAX_READS(MAX_READS)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .use_dq7(use_dq7),
        .tgt_addr(tgt_addr), .exp_data(exp_data), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .rst_cmd_req(rst_cmd_req), .busy(busy),
        .res_valid(res_valid), .res_code(res_code)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [DW-1:0] scr [0:15];
    int            idx = 0;
    int            nreads = 0;
    int            addr_bad = 0;
    int            nrst = 0;
    logic [AW-1:0] want_addr = '0;
    logic          got = 1'b0;
    logic [1:0]    got_code = '0;
    logic          got_rst_before = 1'b0;
    logic          prev_rst = 1'b0;
    int            busy_low = 0;

    function automatic logic [DW-1:0] w(input bit b7, input bit b6, input bit b5, input bit b2);
        return {8'h00, b7, b6, b5, 2'b00, b2, 2'b00};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // scripted flash and result monitor, all at the falling edge
    always @(negedge clk) begin
        if (rd_ack) begin
            rd_ack = 1'b0;
        end else if (rd_req) begin
            rd_ack  = 1'b1;
            rd_data = scr[idx];
            if (idx < 15) idx++;
            nreads++;
            if (rd_addr != want_addr) addr_bad++;
        end
        if (res_valid && !got) begin
            got            = 1'b1;
            got_code       = res_code;
            got_rst_before = prev_rst;
        end
        if (rst_cmd_req) nrst++;
        if (!busy && !got && nreads > 0) busy_low++;
        prev_rst = rst_cmd_req;
    end

    task automatic fill(input logic [DW-1:0] v);
        for (int i = 0; i < 16; i++) scr[i] = v;
    endtask

    task automatic run(input logic [1:0] o, input bit dmode, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [AW-1:0] wa,
                       input bit poke_mid, input string req,
                       input int e_code, input int e_reads, input int e_rst);
        @(negedge clk);
        idx = 0; nreads = 0; addr_bad = 0; nrst = 0; got = 1'b0; busy_low = 0;
        want_addr = wa;
        op = o; use_dq7 = dmode; tgt_addr = a; exp_data = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_mid) begin
            repeat (2) @(negedge clk);
            op = 2'd1; use_dq7 = ~dmode; tgt_addr = ~a;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < 300 && !got; t++) @(negedge clk);
        chk(got, {req, " result seen"}, got, 1);
        chk(got_code == e_code[1:0], {req, " code"}, got_code, e_code);
        chk(nreads == e_reads, {req, " read count"}, nreads, e_reads);
        chk(addr_bad == 0, "R2 poll address", addr_bad, 0);
        chk(nrst == e_rst, {req, " R10 reset requests"}, nrst, e_rst);
        chk(got_rst_before == (e_rst != 0), "R10 reset precedes result", got_rst_before, e_rst);
        chk(busy_low == 0, "R11 busy through operation", busy_low, 0);
        @(negedge clk);
        chk(!busy && !res_valid, "R11 idle after result", busy, 0);
    endtask

    task automatic t_reset;
        chk(!busy && !rd_req && !rst_cmd_req && !res_valid, "R1 reset outputs",
            {busy, rd_req, rst_cmd_req, res_valid}, 0);
    endtask

    task automatic t_toggle_done;   // R4 R5: one toggling pair then a steady pair
        fill(w(0, 0, 0, 0));
        scr[1] = w(0, 1, 0, 0);
        run(2'd0, 1'b0, 12'h5A7, 16'h0000, 12'h5A7, 1'b0, "R4 R5 toggle done", 0, 4, 1);
    endtask

    task automatic t_toggle_recover;   // R6: bit5 rises, recheck finds bit6 steady
        fill(w(0, 1, 0, 0));
        scr[0] = w(0, 0, 0, 0);
        scr[1] = w(0, 1, 1, 0);
        run(2'd3, 1'b0, 12'h123, 16'h0000, 12'h123, 1'b0, "R6 recheck recovers", 0, 4, 1);
    endtask

    task automatic t_toggle_fail;   // R6: recheck still toggling
        fill(w(0, 0, 1, 0));
        scr[1] = w(0, 1, 1, 0);
        scr[3] = w(0, 1, 1, 0);
        run(2'd0, 1'b0, 12'h0F3, 16'h0000, 12'h0F3, 1'b0, "R6 recheck fails", 1, 4, 1);
    endtask

    task automatic t_suspend;   // R7: sector erase, bit6 steady and bit2 moving
        fill(w(0, 1, 0, 1));
        scr[0] = w(0, 1, 0, 0);
        run(2'd1, 1'b0, 12'h5A7, 16'h0000, 12'h5A0, 1'b0, "R7 suspended", 2, 2, 0);
    endtask

    task automatic t_chip_done;   // R2 R4: chip erase, bit2 steady, aligned address
        fill(w(0, 1, 0, 1));
        run(2'd2, 1'b0, 12'hABC, 16'h0000, 12'hAB0, 1'b0, "R2 R4 chip erase", 0, 2, 1);
    endtask

    task automatic t_prog_suspend_ignored;   // R7: program never reports suspension
        fill(w(0, 1, 0, 1));
        scr[0] = w(0, 1, 0, 0);
        run(2'd0, 1'b0, 12'h301, 16'h0000, 12'h301, 1'b0, "R7 program bit2 ignored", 0, 2, 1);
    endtask

    task automatic t_data_done;   // R8 R11: two mismatches then a match, start mid-run ignored
        fill(w(1, 0, 0, 0));
        scr[0] = w(0, 0, 0, 0);
        scr[1] = w(0, 1, 0, 0);
        run(2'd0, 1'b1, 12'h2C5, 16'h0080, 12'h2C5, 1'b1, "R8 R11 data poll", 0, 3, 1);
    endtask

    task automatic t_data_fail;   // R8: bit5 set, reread still mismatches
        fill(w(0, 0, 1, 0));
        run(2'd0, 1'b1, 12'h444, 16'h0080, 12'h444, 1'b0, "R8 data fail", 1, 2, 1);
    endtask

    task automatic t_data_recover;   // R8: bit5 set, reread matches (expected bit 0)
        fill(w(0, 0, 0, 0));
        scr[0] = w(1, 0, 1, 0);
        run(2'd0, 1'b1, 12'h010, 16'h007F, 12'h010, 1'b0, "R8 data recheck", 0, 2, 1);
    endtask

    task automatic t_data_erase;   // R8: erase expects bit7 = 1 whatever exp_data says
        fill(w(1, 0, 0, 0));
        scr[0] = w(0, 0, 0, 0);
        run(2'd1, 1'b1, 12'h7FF, 16'h0000, 12'h7F0, 1'b0, "R8 data erase", 0, 2, 1);
    endtask

    task automatic t_timeouts;   // R9
        fill(w(0, 0, 0, 0));
        run(2'd0, 1'b1, 12'h111, 16'h0080, 12'h111, 1'b0, "R9 data timeout", 3, 8, 1);
        for (int i = 0; i < 16; i++) scr[i] = w(0, i[0], 0, 0);
        run(2'd0, 1'b0, 12'h222, 16'h0000, 12'h222, 1'b0, "R9 toggle timeout", 3, 8, 1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) scr[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_toggle_done();
        t_toggle_recover();
        t_toggle_fail();
        t_suspend();
        t_chip_done();
        t_prog_suspend_ignored();
        t_data_done();
        t_data_fail();
        t_data_recover();
        t_data_erase();
        t_timeouts();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule